// File: doc/BRIEF.md
# Interrupt Distributor Register Front-End

This block is the register decoder of a simplified interrupt distributor that runs with one security state and routes every interrupt as Group 1. A host issues 32-bit word reads and writes on a plain bus made of an address, a read strobe, a write strobe and write data. Read data comes back two clock cycles after the read strobe, tagged by a valid pulse.

The block holds a control word, a type word computed from the configured interrupt count, and an identification word that reports architecture version 3. It keeps enable and pending bitmaps for the shared interrupts, which sit above the first 32 private ones. These bitmaps are reached through separate set and clear windows. One 8-bit priority per shared interrupt sits in a word-wide RAM. Windows for features that are not carried all answer with fixed data and drop writes. Priority ordering, active state and the processor interface live elsewhere.

Top module: `irq_dist_regs`

## Requirements
- R1: In the control word at offset 0x000, bit 4 (affinity routing on) and bit 6 (single security state) always read 1, and writes cannot clear them.
- R2: Control bit 1 (Group 1 enable) is written and read back. Bit 0 (Group 0 enable) always reads 0, even after a write of 1. Every other control bit reads 0. Reset clears bit 1.
- R3: The type word at offset 0x004 reads min(NUM_IRQ,1024)/32-1 in bits [4:0] and 9 (ten ID bits) in bits [23:19]. All other bits read 0, including bit 17 (LPI support) and bit 16 (message interrupts). With 96 interrupts it reads 0x00480002.
- R4: The set-enable window at 0x100 and the clear-enable window at 0x180 each hold one 32-bit word per 32 interrupts, and word n covers interrupts 32n..32n+31 with bit i for interrupt 32n+i. A write to the set window ORs the data into the state. A write to the clear window removes the bits that are written as 1. A read of either window returns the state. Reset clears the state.
- R5: The set-pending window at 0x200 and the clear-pending window at 0x280 behave in the same way on a separate pending state. Writes to them leave the enable state unchanged, and writes to the enable windows leave the pending state unchanged.
- R6: Word 0 of the four bitmap windows, which covers the private interrupts, reads 0 and ignores writes. So does every word at or beyond NUM_IRQ/32.
- R7: The priority window at 0x400..0x7FF holds, in bits [8b+7:8b] of word n, the priority of interrupt 4n+b. A written word reads back unchanged. Words for interrupts below 32 or at or above NUM_IRQ read 0 and ignore writes. Reset does not clear the priorities.
- R8: The group window 0x080..0x0FC reads 0xFFFFFFFF and ignores writes.
- R9: The identification word at offset 0xFFE8 reads 0x0000003B. Every other word of 0xFFD0..0xFFFC reads 0.
- R10: The active set/clear windows (0x300..0x3FF), the target window (0x800..0xBFF), the status word (0x010) and every other unmapped word read 0. A write to any of them changes no state.
- R11: A read strobe sampled at a clock edge gives rvalid high, with its data, after the second following edge. rvalid is never high otherwise. A read and a write in the same cycle return the state from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one word per cycle |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid when rvalid is high |
| rvalid | output | 1 | Read data valid, two cycles after rd_en |

## Verification
The bitmap windows get walking single bits, dense alternating patterns and all-ones words. These show whether set and clear act per bit and whether the enable and pending states stay apart. The private word and the word past the last line take all-ones writes, and the neighbouring live words are read back afterwards, so a write that leaks through the guard is caught. Priority words take distinct byte values, which exposes byte swaps and a wrong mapping from word to RAM address. A read issued in the same cycle as a write to the same word, and back-to-back reads, pin down the two-cycle return and show that the read takes the state from before the write.

// File: rtl/idr_pkg.sv
package idr_pkg;

  // Kind of register a word address resolves to
  typedef enum logic [3:0] {
    WIN_ZERO,
    WIN_ONES,
    WIN_CTRL,
    WIN_TYPE,
    WIN_ID2,
    WIN_SETEN,
    WIN_CLREN,
    WIN_SETPND,
    WIN_CLRPND,
    WIN_PRIO
  } win_e;

  // Control word bit positions
  localparam int CTRL_G0     = 0;
  localparam int CTRL_G1     = 1;
  localparam int CTRL_ROUTE  = 4;
  localparam int CTRL_ONESEC = 6;

  // Type word layout
  localparam int TYPE_IDW_LSB = 19;
  localparam int ID_BITS      = 10;

  // Word offsets of the decoded regions
  localparam int OFF_CTRL     = 'h000;
  localparam int OFF_TYPE     = 'h004;
  localparam int OFF_ONES_LO  = 'h080;
  localparam int OFF_BMAP_LO  = 'h100;
  localparam int OFF_BMAP_HI  = 'h300;
  localparam int OFF_PRIO_LO  = 'h400;
  localparam int OFF_PRIO_HI  = 'h800;
  localparam int ID2_FROM_TOP = 24;

  localparam logic [31:0] ID2_VALUE = 32'h0000_003B;
  localparam int PRIV_IRQS = 32;

endpackage

// File: rtl/idr_decode.sv
module idr_decode
  import idr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_IRQ = 96
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [7:0]        idx
);

  localparam int NUM_WORDS  = NUM_IRQ / 32;
  localparam int PRIO_WORDS = NUM_IRQ / 4;
  localparam int PRIV_PRIO  = PRIV_IRQS / 4;
  localparam int ID2_OFF    = (1 << ADDR_W) - ID2_FROM_TOP;

  logic [ADDR_W-1:0] a;

  always_comb begin
    a   = {addr[ADDR_W-1:2], 2'b00};
    win = WIN_ZERO;
    idx = '0;
    if (a == ADDR_W'(OFF_CTRL)) begin
      win = WIN_CTRL;
    end else if (a == ADDR_W'(OFF_TYPE)) begin
      win = WIN_TYPE;
    end else if (a >= ADDR_W'(OFF_ONES_LO) && a < ADDR_W'(OFF_BMAP_LO)) begin
      win = WIN_ONES;
    end else if (a >= ADDR_W'(OFF_BMAP_LO) && a < ADDR_W'(OFF_BMAP_HI)) begin
      idx = {3'b000, a[6:2]};
      if (idx != 8'd0 && int'(idx) < NUM_WORDS) begin
        case (a[9:7])
          3'd2:    win = WIN_SETEN;
          3'd3:    win = WIN_CLREN;
          3'd4:    win = WIN_SETPND;
          3'd5:    win = WIN_CLRPND;
          default: win = WIN_ZERO;
        endcase
      end
    end else if (a >= ADDR_W'(OFF_PRIO_LO) && a < ADDR_W'(OFF_PRIO_HI)) begin
      idx = a[9:2];
      if (int'(idx) >= PRIV_PRIO && int'(idx) < PRIO_WORDS) begin
        win = WIN_PRIO;
      end
    end else if (a == ADDR_W'(ID2_OFF)) begin
      win = WIN_ID2;
    end
  end

endmodule

// File: rtl/idr_bitmap.sv
module idr_bitmap #(
  parameter int NUM_IRQ = 96
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        set_we,
  input  logic        clr_we,
  input  logic [7:0]  widx,
  input  logic [31:0] wbits,
  input  logic [7:0]  ridx,
  output logic [31:0] rbits
);

  localparam int NUM_WORDS = NUM_IRQ / 32;
  localparam int IW        = $clog2(NUM_WORDS + 1);

  logic [31:0]             st [NUM_WORDS];
  logic [NUM_WORDS*32-1:0] flat;

  // Word 0 (private lines) is never written and stays zero
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WORDS; w++) st[w] <= '0;
    end else begin
      for (int w = 1; w < NUM_WORDS; w++) begin
        if (set_we && int'(widx) == w)      st[w] <= st[w] | wbits;
        else if (clr_we && int'(widx) == w) st[w] <= st[w] & ~wbits;
      end
    end
  end

  always_comb begin
    rbits = '0;
    if (int'(ridx) < NUM_WORDS) rbits = st[ridx[IW-1:0]];
  end

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) flat[w*32 +: 32] = st[w];
  end

  AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((~flat & $past(flat)) == '0)); // R4
  AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((flat & ~$past(flat)) == '0)); // R4

endmodule

// File: rtl/idr_prio_ram.sv
module idr_prio_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import idr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_IRQ = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid
);

  localparam int CAPPED     = (NUM_IRQ < 1024) ? NUM_IRQ : 1024;
  localparam int LINES      = CAPPED / 32 - 1;
  localparam int PRIO_DEPTH = (NUM_IRQ - PRIV_IRQS) / 4;
  localparam int PAW        = $clog2(PRIO_DEPTH);
  localparam logic [31:0] TYPE_VAL =
    (32'(ID_BITS - 1) << TYPE_IDW_LSB) | 32'(LINES);

  win_e        dec_win;
  logic [7:0]  dec_idx;
  logic        grp1_en;
  logic        ctrl_we;
  logic [31:0] en_rbits, pnd_rbits, prio_q;
  logic [PAW-1:0] prio_addr;

  // Stage-1 read capture
  logic        rd_q;
  win_e        win_q;
  logic [31:0] bm_q;
  logic        g1_q;
  logic [31:0] rmux;

  idr_decode #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_dec (
    .addr (addr),
    .win  (dec_win),
    .idx  (dec_idx)
  );

  assign ctrl_we = wr_en && (dec_win == WIN_CTRL);

  always_ff @(posedge clk) begin
    if (rst)          grp1_en <= 1'b0;
    else if (ctrl_we) grp1_en <= wdata[CTRL_G1];
  end

  idr_bitmap #(.NUM_IRQ(NUM_IRQ)) u_enable (
    .clk    (clk),
    .rst    (rst),
    .set_we (wr_en && dec_win == WIN_SETEN),
    .clr_we (wr_en && dec_win == WIN_CLREN),
    .widx   (dec_idx),
    .wbits  (wdata),
    .ridx   (dec_idx),
    .rbits  (en_rbits)
  );

  idr_bitmap #(.NUM_IRQ(NUM_IRQ)) u_pending (
    .clk    (clk),
    .rst    (rst),
    .set_we (wr_en && dec_win == WIN_SETPND),
    .clr_we (wr_en && dec_win == WIN_CLRPND),
    .widx   (dec_idx),
    .wbits  (wdata),
    .ridx   (dec_idx),
    .rbits  (pnd_rbits)
  );

  assign prio_addr = PAW'(dec_idx - 8'(PRIV_IRQS / 4));

  idr_prio_ram #(.DEPTH(PRIO_DEPTH), .AW(PAW)) u_prio (
    .clk   (clk),
    .we    (wr_en && dec_win == WIN_PRIO),
    .waddr (prio_addr),
    .wdata (wdata),
    .re    (rd_en && dec_win == WIN_PRIO),
    .raddr (prio_addr),
    .rdata (prio_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      win_q <= WIN_ZERO;
      bm_q  <= '0;
      g1_q  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (rd_en) begin
        win_q <= dec_win;
        bm_q  <= (dec_win == WIN_SETEN || dec_win == WIN_CLREN) ? en_rbits : pnd_rbits;
        g1_q  <= grp1_en;
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (win_q)
      WIN_CTRL: begin
        rmux[CTRL_ROUTE]  = 1'b1;
        rmux[CTRL_ONESEC] = 1'b1;
        rmux[CTRL_G1]     = g1_q;
      end
      WIN_TYPE:   rmux = TYPE_VAL;
      WIN_ONES:   rmux = '1;
      WIN_ID2:    rmux = ID2_VALUE;
      WIN_SETEN, WIN_CLREN, WIN_SETPND, WIN_CLRPND: rmux = bm_q;
      WIN_PRIO:   rmux = prio_q;
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_q;
      rdata  <= rd_q ? rmux : '0;
    end
  end

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 rvalid); // R11
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en, 2)); // R11
  AST_G1_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(grp1_en)); // R2
  AST_CTRL_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    (rvalid && $past(win_q) == WIN_CTRL) |->
      (rdata[CTRL_ROUTE] && rdata[CTRL_ONESEC] && !rdata[CTRL_G0])); // R1

endmodule

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;

  localparam int ADDR_W  = 16;
  localparam int NUM_IRQ = 96;
  localparam int NWORDS  = NUM_IRQ / 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rvalid;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  irq_dist_regs #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  // Behavioural reference state
  bit          m_g1;
  logic [31:0] m_en [NWORDS];
  logic [31:0] m_pd [NWORDS];
  logic [7:0]  m_pr [NUM_IRQ];

  logic [31:0] exp_q [$];
  int          due_q [$];
  int          adr_q [$];
  string       tag_q [$];

  function automatic logic [31:0] mread(int a);
    int w, n;
    a = a & 'hFFFC;
    if (a == 0) return 32'h50 | (32'(m_g1) << 1);
    if (a == 4) return 32'((NUM_IRQ / 32) - 1) | (32'd9 << 19);
    if (a >= 'h80 && a < 'h100) return 32'hFFFF_FFFF;
    if (a >= 'h100 && a < 'h300) begin
      w = (a >> 2) & 31;
      if (w == 0 || w >= NWORDS) return 0;
      return (a < 'h200) ? m_en[w] : m_pd[w];
    end
    if (a >= 'h400 && a < 'h800) begin
      n = (a - 'h400) >> 2;
      if (n < 8 || n >= NUM_IRQ / 4) return 0;
      return {m_pr[4*n+3], m_pr[4*n+2], m_pr[4*n+1], m_pr[4*n]};
    end
    if (a == 'hFFE8) return 32'h3B;
    return 0;
  endfunction

  task automatic mwrite(int a, logic [31:0] d);
    int w, n;
    a = a & 'hFFFC;
    if (a == 0) m_g1 = d[1];
    else if (a >= 'h100 && a < 'h300) begin
      w = (a >> 2) & 31;
      if (w != 0 && w < NWORDS) begin
        case ((a - 'h100) >> 7)
          0: m_en[w] = m_en[w] | d;
          1: m_en[w] = m_en[w] & ~d;
          2: m_pd[w] = m_pd[w] | d;
          default: m_pd[w] = m_pd[w] & ~d;
        endcase
      end
    end else if (a >= 'h400 && a < 'h800) begin
      n = (a - 'h400) >> 2;
      if (n >= 8 && n < NUM_IRQ / 4)
        for (int b = 0; b < 4; b++) m_pr[4*n+b] = d[8*b +: 8];
    end
  endtask

  task automatic op(bit rd, bit wr, int a, logic [31:0] d, string tag);
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = ADDR_W'(a); wdata = d;
    if (rd) begin
      exp_q.push_back(mread(a)); due_q.push_back(cyc + 2);
      adr_q.push_back(a); tag_q.push_back(tag);
    end
    if (wr) mwrite(a, d);
  endtask

  task automatic rd(int a, string tag);  op(1, 0, a, 32'h0, tag); endtask
  task automatic wr(int a, logic [31:0] d); op(0, 1, a, d, ""); endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_en = 0; wr_en = 0;
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        tests++;
        if (!rvalid || rdata !== exp_q[0]) begin
          fails++;
          $display("FAIL %s addr=0x%04h rvalid=%0b actual=0x%08h expected=0x%08h",
                   tag_q[0], adr_q[0], rvalid, rdata, exp_q[0]);
        end
        void'(exp_q.pop_front()); void'(due_q.pop_front());
        void'(adr_q.pop_front()); void'(tag_q.pop_front());
      end else if (rvalid) begin
        tests++; fails++;
        $display("FAIL R11 stray rvalid actual=1 expected=0 at cycle %0d", cyc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_g1 = 0;
    for (int w = 0; w < NWORDS; w++) begin m_en[w] = 0; m_pd[w] = 0; end
    for (int i = 0; i < NUM_IRQ; i++) m_pr[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tests++;
    if (rvalid !== 1'b0 || rdata !== 32'h0) begin
      fails++;
      $display("FAIL R11 reset actual=%0b/0x%08h expected=0/0x00000000", rvalid, rdata);
    end

    // R1 R2 control word
    rd('h000, "R1");
    wr('h000, 32'hFFFF_FFFF); rd('h000, "R2 g1 set, g0 stays 0");
    wr('h000, 32'h0);         rd('h000, "R1 fixed bits survive zero write");
    wr('h000, 32'h0000_0002); rd('h000, "R2");
    // R3 type word
    rd('h004, "R3"); wr('h004, 32'h0); rd('h004, "R3 after write");
    // R8 group window
    rd('h080, "R8"); wr('h0FC, 32'h0); rd('h0FC, "R8 after write");
    // R4 enable set/clear
    wr('h104, 32'hA5A5_0001); rd('h104, "R4 set"); rd('h184, "R4 clear window view");
    wr('h184, 32'hA000_0001); rd('h104, "R4 after clear");
    for (int b = 0; b < 32; b += 7) begin
      wr('h108, 32'h1 << b); rd('h188, "R4 walking bit");
    end
    wr('h108, 32'hFFFF_FFFF); wr('h188, 32'h5555_5555); rd('h108, "R4 partial clear");
    // R5 pending, independent of enable
    wr('h204, 32'h0F0F_F0F0); rd('h284, "R5 set");
    wr('h284, 32'h0000_00F0); rd('h204, "R5 clear");
    rd('h104, "R5 enable untouched by pending");
    wr('h188, 32'hFFFF_FFFF); rd('h208, "R5 pending untouched by enable");
    // R6 private word and out-of-range word
    wr('h100, 32'hFFFF_FFFF); wr('h200, 32'hFFFF_FFFF);
    rd('h100, "R6 private enable"); rd('h280, "R6 private pending");
    wr('h10C, 32'hFFFF_FFFF); rd('h10C, "R6 beyond last line");
    rd('h104, "R6 neighbour word1"); rd('h108, "R6 neighbour word2");
    // R7 priorities
    wr('h420, 32'h1122_3344); wr('h45C, 32'hDEAD_BEEF); wr('h440, 32'h8070_6050);
    rd('h420, "R7 first shared"); rd('h45C, "R7 last shared"); rd('h440, "R7 mid");
    wr('h400, 32'hFFFF_FFFF); rd('h400, "R7 private priority");
    wr('h460, 32'hFFFF_FFFF); rd('h460, "R7 beyond last");
    rd('h420, "R7 unchanged by ignored writes");
    // R9 identification
    rd('hFFE8, "R9 id2"); rd('hFFD0, "R9 other id"); rd('hFFFC, "R9 other id");
    wr('hFFE8, 32'h0); rd('hFFE8, "R9 after write");
    // R10 zero windows
    wr('h300, 32'hFFFF_FFFF); wr('h380, 32'hFFFF_FFFF);
    wr('h800, 32'hFFFF_FFFF); wr('h010, 32'hFFFF_FFFF); wr('h1000, 32'hFFFF_FFFF);
    rd('h300, "R10 active"); rd('h380, "R10 active clear"); rd('h800, "R10 target");
    rd('h010, "R10 status"); rd('h1000, "R10 unmapped");
    rd('h104, "R10 enable unchanged"); rd('h204, "R10 pending unchanged");
    rd('h420, "R10 priority unchanged"); rd('h000, "R10 control unchanged");
    // R11 read alongside write returns old state; back-to-back reads
    op(1, 1, 'h104, 32'h0000_00F0, "R11 read with write");
    rd('h104, "R11 next read sees write");
    rd('h004, "R11 back-to-back");
    idle(6);
    if (due_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R11 missing rvalid actual=%0d pending expected=0", due_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule